// File: doc/BRIEF.md
# SPI register-access target

This block is an SPI slave that gives an external controller word-level access to an internal register bus. Each chip-select frame opens with a 32-bit command header. The header carries the direction, a read word count and a starting word address. In a write frame, 32-bit data words follow the header on MOSI, and each complete word becomes one write on the register bus. In a read frame, the block fetches words from the register bus and shifts them out on MISO in the word slots that follow the header, inside the same frame.

The SPI pins are oversampled by the system clock through synchronizers, and SCLK edges are detected in the system domain. The SPI format is mode 0: MOSI is sampled on rising SCLK, MISO changes after falling SCLK, and all data is MSB first. A frame carries at most `MAX_WORDS` payload words (64 by default). The word address advances by one per payload word and wraps modulo 2^21.

The control state machine has five states:
- `ST_IDLE`: CS high.
- `ST_HDR`: collecting the header.
- `ST_WR`: write payload.
- `ST_RD`: read payload.
- `ST_DRAIN`: write payload past the limit, where further words are ignored.

The state transitions are:
- `ST_IDLE` goes to `ST_HDR` when CS asserts.
- `ST_HDR` goes to `ST_WR` or `ST_RD` on the 32nd header bit, chosen by the direction bit.
- `ST_WR` goes to `ST_DRAIN` after the last permitted write word.
- Every other state returns to `ST_IDLE` when CS deasserts.

Top module: `srb_target`

## Requirements
- R1: While CS is high, including directly after reset, MISO is 0 and no register-bus strobe occurs, and SCLK toggling has no effect. MISO is 0 during the 32 header bits of every frame.
- R2: Header bit 31 selects the direction (1 = write, 0 = read). Bits 30:25 are the read word count, bits 24:4 are the starting word address, and bits 3:0 are ignored.
- R3: In a write frame, every complete 32-bit word after the header produces exactly one `bus_wr_en` pulse of one cycle. That pulse carries the word in `bus_wdata`, at address base+0, base+1, and so on. The count field has no effect on writes.
- R4: A write frame produces at most `MAX_WORDS` writes, and further payload words are ignored.
- R5: A partial word that is pending when CS deasserts produces no write.
- R6: In a read frame, payload word slot i on MISO carries the `bus_rdata` value returned for address base+i, sent MSB first. The block issues one `bus_rd_en` pulse per requested word, and `bus_rdata` is taken in the cycle after the pulse. This requires each SCLK phase to last at least 6 system clocks.
- R7: A read count of 0 issues no reads, and a count above `MAX_WORDS` is clipped to `MAX_WORDS`. Every MISO slot beyond the effective count is all zeros.
- R8: Payload addresses wrap modulo 2^21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select, framing a transfer |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| bus_wr_en | output | 1 | One-cycle register write strobe |
| bus_rd_en | output | 1 | One-cycle register read strobe |
| bus_addr | output | 21 | Word address for the strobe |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after `bus_rd_en` |

## Verification
The bench builds the block with `MAX_WORDS` = 8 and two synchronizer stages. With these values the write limit, the clipping of a read count and the zero-filled slots past the count all fall within frames of about ten words. That makes it affordable to sweep every write length from 0 to 10 and every read count from 0 to 10, plus the largest count field of 63. Base addresses at the top of the 21-bit space bring the wrap within reach. Frames cut off 16 or 31 bits into a word cover the discard rule.

// File: rtl/srb_pkg.sv
package srb_pkg;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 6;
    localparam int ADDR_W    = 21;
    localparam int ADR_LO    = 4;
    localparam int ADR_HI    = ADR_LO + ADDR_W - 1;
    localparam int CNT_LO    = ADR_HI + 1;
    localparam int CNT_HI    = CNT_LO + CNT_W - 1;
    localparam int DIR_BIT   = CNT_HI + 1;
    localparam int BIT_CNT_W = $clog2(WORD_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WR,
        ST_RD,
        ST_DRAIN
    } srb_state_t;
endpackage

// File: rtl/srb_sync.sv
module srb_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{INIT}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/srb_shifter.sv
module srb_shifter
    import srb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              rise,
    input  logic              fall,
    input  logic              mosi_bit,
    input  logic [WORD_W-1:0] load_val,
    output logic [WORD_W-1:0] rx_word,
    output logic              word_done,
    output logic              load_evt,
    output logic              miso
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(WORD_W - 1);

    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [WORD_W-1:0]    tx_sh;

    // a falling edge at a word boundary starts a new outgoing word
    assign load_evt = active && fall && (bit_cnt == '0);
    assign miso     = tx_sh[WORD_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_word   <= '0;
            word_done <= 1'b0;
            tx_sh     <= '0;
        end else if (!active) begin
            bit_cnt   <= '0;
            word_done <= 1'b0;
            tx_sh     <= '0;
        end else begin
            word_done <= 1'b0;
            if (rise) begin
                rx_word   <= {rx_word[WORD_W-2:0], mosi_bit};
                bit_cnt   <= bit_cnt + 1'b1;
                word_done <= (bit_cnt == LAST_BIT);
            end
            if (fall) begin
                tx_sh <= load_evt ? load_val : {tx_sh[WORD_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/srb_target.sv
module srb_target
    import srb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_WORDS   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              bus_wr_en,
    output logic              bus_rd_en,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata
);
    localparam int                WCNT_W    = $clog2(MAX_WORDS + 1);
    localparam logic [WCNT_W-1:0] WCNT_LAST = WCNT_W'(MAX_WORDS - 1);
    localparam logic [2:0]        PIN_INIT  = 3'b100;

    // ---- pin synchronizers: {cs_n, sclk, mosi} ----
    logic [2:0] pin_raw, pin_s;
    assign pin_raw = {spi_cs_n, spi_sclk, spi_mosi};

    for (genvar g = 0; g < 3; g++) begin : g_sync
        srb_sync #(.STAGES(SYNC_STAGES), .INIT(PIN_INIT[g])) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pin_raw[g]),
            .q     (pin_s[g])
        );
    end

    logic sclk_d, active, rise, fall;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= pin_s[1];
    end
    assign active = !pin_s[2];
    assign rise   = active &&  pin_s[1] && !sclk_d;
    assign fall   = active && !pin_s[1] &&  sclk_d;

    // ---- shifter ----
    logic [WORD_W-1:0] rx_word, load_val, pref;
    logic              word_done, load_evt, pref_ok, rd_pend;

    srb_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .rise      (rise),
        .fall      (fall),
        .mosi_bit  (pin_s[0]),
        .load_val  (load_val),
        .rx_word   (rx_word),
        .word_done (word_done),
        .load_evt  (load_evt),
        .miso      (spi_miso)
    );

    // ---- control ----
    srb_state_t        state, nstate;
    logic [ADDR_W-1:0] base;
    logic [WCNT_W-1:0] wcnt, rcount, hdr_clip;
    logic [CNT_W-1:0]  hdr_cnt;
    logic              rd_more;

    assign hdr_cnt  = rx_word[CNT_HI:CNT_LO];
    assign hdr_clip = (int'(hdr_cnt) > MAX_WORDS) ? WCNT_W'(MAX_WORDS) : WCNT_W'(hdr_cnt);
    assign rd_more  = (int'(wcnt) + 1) < int'(rcount);
    assign load_val = (state == ST_RD && pref_ok) ? pref : '0;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (active) nstate = ST_HDR;
            ST_HDR:   if (!active) nstate = ST_IDLE;
                      else if (word_done) nstate = rx_word[DIR_BIT] ? ST_WR : ST_RD;
            ST_WR:    if (!active) nstate = ST_IDLE;
                      else if (word_done && wcnt == WCNT_LAST) nstate = ST_DRAIN;
            ST_RD:    if (!active) nstate = ST_IDLE;
            ST_DRAIN: if (!active) nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_wr_en <= 1'b0;
            bus_rd_en <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            base      <= '0;
            rcount    <= '0;
            wcnt      <= '0;
            rd_pend   <= 1'b0;
            pref      <= '0;
            pref_ok   <= 1'b0;
        end else begin
            bus_wr_en <= 1'b0;
            bus_rd_en <= 1'b0;
            rd_pend   <= bus_rd_en;
            if (rd_pend) begin
                pref    <= bus_rdata;
                pref_ok <= 1'b1;
            end else if (load_evt) begin
                pref_ok <= 1'b0;
            end
            unique case (state)
                ST_IDLE: begin
                    wcnt    <= '0;
                    pref_ok <= 1'b0;
                end
                ST_HDR: if (word_done) begin
                    base   <= rx_word[ADR_HI:ADR_LO];
                    rcount <= hdr_clip;
                    wcnt   <= '0;
                    if (!rx_word[DIR_BIT] && hdr_clip != '0) begin
                        bus_rd_en <= 1'b1;
                        bus_addr  <= rx_word[ADR_HI:ADR_LO];
                    end
                end
                ST_WR: if (word_done) begin
                    bus_wr_en <= 1'b1;
                    bus_addr  <= base + ADDR_W'(wcnt);
                    bus_wdata <= rx_word;
                    wcnt      <= wcnt + 1'b1;
                end
                ST_RD: if (word_done) begin
                    if (int'(wcnt) < MAX_WORDS) wcnt <= wcnt + 1'b1;
                    if (rd_more) begin
                        bus_rd_en <= 1'b1;
                        bus_addr  <= base + ADDR_W'(wcnt) + 1'b1;
                    end
                end
                ST_DRAIN: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/srb_target_chk.sv
module srb_target_chk
    import srb_pkg::*;
#(
    parameter int MAX_WORDS = 64
) (
    input logic              clk,
    input logic              rst_n,
    input srb_state_t        state,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              spi_miso
);
    logic [15:0]       wr_n, rd_n;
    logic [ADDR_W-1:0] last_wa, last_ra;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_n    <= '0;
            rd_n    <= '0;
            last_wa <= '0;
            last_ra <= '0;
        end else if (state == ST_IDLE) begin
            wr_n <= '0;
            rd_n <= '0;
        end else begin
            if (bus_wr_en) begin
                wr_n    <= wr_n + 1'b1;
                last_wa <= bus_addr;
            end
            if (bus_rd_en) begin
                rd_n    <= rd_n + 1'b1;
                last_ra <= bus_addr;
            end
        end
    end

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && bus_rd_en));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (!bus_wr_en && !bus_rd_en));

    assert_hdr_miso_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR) |-> !spi_miso);

    assert_wr_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wr_n) <= MAX_WORDS);

    assert_rd_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_n) <= MAX_WORDS);

    assert_wr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && state != ST_IDLE && wr_n != '0) |-> (bus_addr == last_wa + 1'b1));

    assert_rd_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && state != ST_IDLE && rd_n != '0) |-> (bus_addr == last_ra + 1'b1));

    assert_no_rd_in_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR || state == ST_DRAIN) |=> !bus_rd_en);
endmodule

bind srb_target srb_target_chk #(.MAX_WORDS(MAX_WORDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .spi_miso  (spi_miso)
);

// File: tb/srb_target_test.sv
module srb_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8 * CLK_PERIOD;
    localparam int MAXW       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        bus_wr_en, bus_rd_en;
    logic [20:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = 32'h0;

    int checks = 0;
    int fails  = 0;
    int wn = 0;
    int rn = 0;
    bit finished = 0;

    logic [20:0] wa [0:1023];
    logic [31:0] wd [0:1023];
    logic [20:0] ra [0:1023];
    logic [31:0] txw [0:79];
    logic [31:0] rxw [0:79];

    srb_target #(.SYNC_STAGES(2), .MAX_WORDS(MAXW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] rd_model(input logic [20:0] a);
        return {~a[10:0], a};
    endfunction

    // register-bus model and strobe log
    always @(posedge clk) begin
        if (bus_rd_en) begin
            bus_rdata <= rd_model(bus_addr);
            ra[rn % 1024] <= bus_addr;
            rn <= rn + 1;
        end
        if (bus_wr_en) begin
            wa[wn % 1024] <= bus_addr;
            wd[wn % 1024] <= bus_wdata;
            wn <= wn + 1;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic spi_frame(input int nwords, input int extra_bits);
        int total;
        total = nwords * 32 + extra_bits;
        spi_cs_n = 1'b0;
        #(HALF);
        for (int i = 0; i < total; i++) begin
            spi_mosi = txw[i / 32][31 - (i % 32)];
            #(HALF);
            spi_sclk = 1'b1;
            rxw[i / 32][31 - (i % 32)] = spi_miso;
            #(HALF);
            spi_sclk = 1'b0;
        end
        #(HALF);
        spi_cs_n = 1'b1;
        #(2 * HALF);
    endtask

    task automatic do_write(input logic [20:0] base, input int n, input int extra,
                            input logic [5:0] cntf, input logic [3:0] low, input string req);
        int w0;
        int expn;
        logic [20:0] ea;
        w0 = wn;
        expn = (n < MAXW) ? n : MAXW;
        txw[0] = {1'b1, cntf, base, low};
        for (int i = 1; i <= n + 1; i++)
            txw[i] = (32'(i) * 32'h9E3779B9) ^ {base, 11'h2A5};
        spi_frame(n + 1, extra);
        check(req, "write count", 64'(wn - w0), 64'(expn));
        for (int i = 0; i < expn; i++) begin
            ea = base + 21'(i);
            check(req, "write addr", 64'(wa[(w0 + i) % 1024]), 64'(ea));
            check(req, "write data", 64'(wd[(w0 + i) % 1024]), 64'(txw[i + 1]));
        end
    endtask

    task automatic do_read(input logic [20:0] base, input logic [5:0] cntf,
                           input int extra_words, input logic [3:0] low, input string req);
        int r0;
        int expn;
        int pay;
        logic [20:0] ea;
        logic [31:0] ev;
        r0 = rn;
        expn = (int'(cntf) < MAXW) ? int'(cntf) : MAXW;
        pay = expn + extra_words;
        txw[0] = {1'b0, cntf, base, low};
        for (int i = 1; i <= pay; i++) txw[i] = 32'hC3C3_0000 ^ 32'(i);
        spi_frame(pay + 1, 0);
        check("R1", "miso during header", 64'(rxw[0]), 64'h0);
        check(req, "read strobe count", 64'(rn - r0), 64'(expn));
        for (int i = 0; i < expn; i++) begin
            ea = base + 21'(i);
            check(req, "read addr", 64'(ra[(r0 + i) % 1024]), 64'(ea));
        end
        for (int i = 0; i < pay; i++) begin
            ea = base + 21'(i);
            ev = (i < expn) ? rd_model(ea) : 32'h0;
            check((i < expn) ? req : "R7", "miso word", 64'(rxw[i + 1]), 64'(ev));
        end
    endtask

    initial begin
        #(190000 * CLK_PERIOD);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(5 * CLK_PERIOD);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        // R1: quiet after reset, SCLK toggling with CS high has no effect
        check("R1", "miso after reset", 64'(spi_miso), 64'h0);
        check("R1", "wr strobe after reset", 64'(bus_wr_en), 64'h0);
        for (int i = 0; i < 40; i++) begin
            spi_mosi = i[0];
            #(HALF); spi_sclk = 1'b1;
            #(HALF); spi_sclk = 1'b0;
        end
        check("R1", "writes with cs high", 64'(wn), 64'h0);
        check("R1", "reads with cs high", 64'(rn), 64'h0);
        check("R1", "miso with cs high", 64'(spi_miso), 64'h0);

        // R3 / R4: write length sweep across the limit
        for (int n = 0; n <= MAXW + 2; n++)
            do_write(21'h01000 + 21'(n * 37), n, 0, 6'h0, 4'h0, (n > MAXW) ? "R4" : "R3");
        // R3: count field and low header bits do not alter a write (R2)
        do_write(21'h0ABCD, 3, 0, 6'h2C, 4'hF, "R2");
        // R5: partial trailing words are discarded
        do_write(21'h00400, 2, 16, 6'h0, 4'h0, "R5");
        do_write(21'h00500, 1, 31, 6'h0, 4'h0, "R5");
        // R8: address wrap on writes
        do_write(21'h1FFFFE, 4, 0, 6'h0, 4'h0, "R8");

        // R6 / R7: read count sweep, each with two trailing slots
        for (int c = 0; c <= MAXW + 2; c++)
            do_read(21'h02000 + 21'(c * 53), 6'(c), 2, 4'h0, (c > MAXW) ? "R7" : "R6");
        do_read(21'h03300, 6'h3F, 1, 4'h0, "R7");
        // R2: low header bits ignored on reads
        do_read(21'h04440, 6'h2, 1, 4'hA, "R2");
        // R8: address wrap on reads
        do_read(21'h1FFFFD, 6'h5, 0, 4'h0, "R8");

        check("R1", "miso idle at end", 64'(spi_miso), 64'h0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule